// File: doc/BRIEF.md
# Oversampling Serial Receiver with Line-Break Detection

This block receives asynchronous serial characters on one input that idles high. It runs on the system clock and moves forward only on cycles where a one-cycle enable arrives at sixteen times the baud rate. The input first passes through a two-flop synchroniser. A falling edge is treated as a start-bit candidate. The block checks the line again half a bit later, so short low pulses are dropped. It then samples each following bit at its centre. It assembles eight data bits, least significant first, and can take an optional parity bit. The character closes with one stop bit.

When a frame is good, the block delivers the byte together with a one-cycle valid strobe. A low stop bit raises a frame-error pulse. A parity bit of the wrong sense raises a parity-error pulse. A second detector watches for a line that stays low. It counts oversample ticks while the line is low, and when the count passes a threshold set in whole character times it fires a single break pulse. A live break status stays high until the line has been high for half a bit. The receive FIFO, the baud tick generator and register decoding live outside this block.

Top module: `oversample_rx`

## Requirements
- R1: After reset, rxValid, parityErr, frameErr, breakPulse and breakActive are 0 and rxData is 0x00. serialIn passes through a two-stage synchroniser, which resets to high, before any logic uses it.
- R2: A low level on the line is confirmed as a start bit only if it is still low 8 ticks after it was first seen. A low pulse shorter than that produces no byte and no error pulse.
- R3: A frame is a 0 start bit, 8 data bits sent least significant bit first, an optional parity bit, and a 1 stop bit. Each bit is sampled 16 ticks after the previous sample point. A good frame drives rxData with the byte and pulses rxValid high for one clock. rxData changes only together with rxValid.
- R4: With parityEnable=1, the parity bit is expected to make the count of ones across data and parity even when parityOdd=0 and odd when parityOdd=1. A mismatch pulses parityErr and suppresses rxValid.
- R5: A stop bit sampled low pulses frameErr for one clock and suppresses rxValid. The receiver then goes straight back to looking for a start bit, so a line held low raises frameErr again every character time.
- R6: breakLevel values 0, 1, 2 and 3 select 2, 4, 8 and 16 character times. A character time is 160 ticks without parity and 176 ticks with parity. breakPulse fires when the line has been low for more than the selected number of ticks.
- R7: Each break produces exactly one breakPulse. breakActive rises with the pulse. It falls only after 8 consecutive high ticks. If the line goes low again before that, no new pulse is produced.
- R8: While rxEnable=0 the receiver and the break detector are held idle. No rxValid, parityErr, frameErr or breakPulse is produced, and breakActive is 0.
- R9: A frame that has both a wrong parity bit and a low stop bit pulses parityErr and frameErr in the same clock, and does not assert rxValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the baud rate |
| rxEnable | input | 1 | Receive enable |
| parityEnable | input | 1 | A parity bit follows the data bits |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| breakLevel | input | 2 | Break threshold select: 2, 4, 8 or 16 character times |
| serialIn | input | 1 | Asynchronous serial input, idles high |
| rxData | output | 8 | Last byte received |
| rxValid | output | 1 | One-cycle strobe when a good byte arrives |
| parityErr | output | 1 | One-cycle pulse on a parity mismatch |
| frameErr | output | 1 | One-cycle pulse on a low stop bit |
| breakPulse | output | 1 | One-cycle pulse when a break is detected |
| breakActive | output | 1 | High while the break lasts |

## Verification
Two error reports can land in the same cycle: the parity check and the stop-bit check, because both are resolved at the stop sample. The bench provokes this by sending a frame with parity enabled, a wrong parity bit and a low stop bit. A monitor that looks at the outputs away from the clock edge judges the result. It must see parityErr and frameErr high in one and the same cycle, and it must see no rxValid. The break test also overlaps repeated frame errors with the break pulse. It judges each count on its own against the low-time thresholds.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_t;

  // Strobes from the control to the datapath, valid for one clock.
  typedef struct packed {
    logic clearFrame;
    logic shiftData;
    logic takeParity;
    logic takeStop;
  } rxStrobes_t;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stages;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stages <= '1;
        else       stages <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stages <= '1;
        else       stages <= {stages[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stages[STAGES-1];

endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       enable,
  input  logic       parityOn,
  input  logic       line,
  output rxStrobes_t strobes
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int HALF  = OVERSAMPLE / 2;

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             fullBit;
  logic             halfBit;

  assign fullBit = (tickCnt == CNT_W'(OVERSAMPLE - 1));
  assign halfBit = (tickCnt == CNT_W'(HALF - 1));

  always_comb begin
    strobes = '0;
    if (enable && tick) begin
      case (state)
        ST_IDLE:   strobes.clearFrame = !line;
        ST_DATA:   strobes.shiftData  = fullBit;
        ST_PARITY: strobes.takeParity = fullBit;
        ST_STOP:   strobes.takeStop   = fullBit;
        default:   strobes = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (!enable) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          bitCnt  <= '0;
          if (!line) state <= ST_START;
        end
        ST_START: begin
          if (halfBit) begin
            tickCnt <= '0;
            state   <= line ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (fullBit) begin
            tickCnt <= '0;
            if (bitCnt == BIT_W'(DATA_BITS - 1)) begin
              bitCnt <= '0;
              state  <= parityOn ? ST_PARITY : ST_STOP;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_PARITY: begin
          if (fullBit) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (fullBit) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: a disabled receiver issues no strobes from the next clock on
  assert_idle_when_off_R8 : assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (strobes == '0));

  // R2: the data phase is entered only from a start bit still low at mid-bit
  assert_start_confirmed_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) && ($past(state) == ST_START) |-> !$past(line));

endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 line,
  input  logic                 parityOn,
  input  logic                 parityOdd,
  input  rxStrobes_t           strobes,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 parityErr,
  output logic                 frameErr
);

  logic [DATA_BITS-1:0] shiftReg;
  logic                 parityBit;
  logic                 parityMiss;

  assign parityMiss = parityOn && (parityBit != ((^shiftReg) ^ parityOdd));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
      rxData    <= '0;
      rxValid   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      rxValid   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      if (strobes.clearFrame) begin
        shiftReg  <= '0;
        parityBit <= 1'b0;
      end
      if (strobes.shiftData) begin
        shiftReg <= {line, shiftReg[DATA_BITS-1:1]};
      end
      if (strobes.takeParity) begin
        parityBit <= line;
      end
      if (strobes.takeStop) begin
        frameErr  <= !line;
        parityErr <= parityMiss;
        if (line && !parityMiss) begin
          rxValid <= 1'b1;
          rxData  <= shiftReg;
        end
      end
    end
  end

  // R4: a delivered byte never comes with an error pulse
  assert_valid_clean_R4 : assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !frameErr && !parityErr);

  // R5: frame errors are single-cycle pulses
  assert_frame_pulse_R5 : assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);

  // R3: the output byte only changes together with the valid strobe
  assert_data_hold_R3 : assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> rxValid);

endmodule

// File: rtl/rx_break.sv
module rx_break #(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16,
  parameter int LEVEL_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic                  enable,
  input  logic                  parityOn,
  input  logic [LEVEL_BITS-1:0] level,
  input  logic                  line,
  output logic                  breakPulse,
  output logic                  breakActive
);

  localparam int BASE_BITS = DATA_BITS + 2;
  localparam int MAX_MUL   = 2 << ((1 << LEVEL_BITS) - 1);
  localparam int MAX_THR   = (BASE_BITS + 1) * OVERSAMPLE * MAX_MUL;
  localparam int CNT_W     = $clog2(MAX_THR + 2);
  localparam int HALF      = OVERSAMPLE / 2;
  localparam int HCNT_W    = $clog2(HALF + 1);

  logic [CNT_W-1:0]  charTicks;
  logic [CNT_W-1:0]  threshold;
  logic [CNT_W-1:0]  lowCnt;
  logic [HCNT_W-1:0] highCnt;
  logic [LEVEL_BITS:0] shiftAmt;

  always_comb begin
    charTicks = parityOn ? CNT_W'((BASE_BITS + 1) * OVERSAMPLE)
                         : CNT_W'(BASE_BITS * OVERSAMPLE);
    shiftAmt  = {1'b0, level} + 1'b1;
    threshold = charTicks << shiftAmt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt      <= '0;
      highCnt     <= '0;
      breakPulse  <= 1'b0;
      breakActive <= 1'b0;
    end else begin
      breakPulse <= 1'b0;
      if (!enable) begin
        lowCnt      <= '0;
        highCnt     <= '0;
        breakActive <= 1'b0;
      end else if (tick) begin
        if (!line) begin
          highCnt <= '0;
          if (lowCnt < threshold) begin
            lowCnt <= lowCnt + 1'b1;
          end else if (!breakActive) begin
            breakPulse  <= 1'b1;
            breakActive <= 1'b1;
          end
        end else begin
          lowCnt <= '0;
          if (breakActive) begin
            if (highCnt == HCNT_W'(HALF - 1)) begin
              highCnt     <= '0;
              breakActive <= 1'b0;
            end else begin
              highCnt <= highCnt + 1'b1;
            end
          end else begin
            highCnt <= '0;
          end
        end
      end
    end
  end

  // R7: a pulse only opens a new break
  assert_single_pulse_R7 : assert property (@(posedge clk) disable iff (!rstN)
    breakPulse |-> breakActive && !$past(breakActive));

  // R7: an enabled break status ends only on a high line
  assert_rearm_high_R7 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(breakActive) && $past(enable) |-> $past(line));

  // R8: disabled detector is quiet
  assert_break_off_R8 : assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !breakPulse && !breakActive);

endmodule

// File: rtl/oversample_rx.sv
module oversample_rx
  import rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_BITS  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick16,
  input  logic                  rxEnable,
  input  logic                  parityEnable,
  input  logic                  parityOdd,
  input  logic [LEVEL_BITS-1:0] breakLevel,
  input  logic                  serialIn,
  output logic [DATA_BITS-1:0]  rxData,
  output logic                  rxValid,
  output logic                  parityErr,
  output logic                  frameErr,
  output logic                  breakPulse,
  output logic                  breakActive
);

  logic       lineSync;
  rxStrobes_t strobes;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (serialIn),
    .dout(lineSync)
  );

  rx_ctrl #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick16),
    .enable  (rxEnable),
    .parityOn(parityEnable),
    .line    (lineSync),
    .strobes (strobes)
  );

  rx_datapath #(.DATA_BITS(DATA_BITS)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .line     (lineSync),
    .parityOn (parityEnable),
    .parityOdd(parityOdd),
    .strobes  (strobes),
    .rxData   (rxData),
    .rxValid  (rxValid),
    .parityErr(parityErr),
    .frameErr (frameErr)
  );

  rx_break #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE), .LEVEL_BITS(LEVEL_BITS)) u_break (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick16),
    .enable     (rxEnable),
    .parityOn   (parityEnable),
    .level      (breakLevel),
    .line       (lineSync),
    .breakPulse (breakPulse),
    .breakActive(breakActive)
  );

endmodule

// File: tb/oversample_rx_test.sv
`timescale 1ns/1ps
module oversample_rx_test;

  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxEnable = 1'b1;
  logic       parityEnable = 1'b0;
  logic       parityOdd = 1'b0;
  logic [1:0] breakLevel = 2'd0;
  logic       serialIn = 1'b1;
  logic [7:0] rxData;
  logic       rxValid, parityErr, frameErr, breakPulse, breakActive;

  int checks = 0;
  int fails  = 0;
  int validCnt = 0, parCnt = 0, frameCnt = 0, breakCnt = 0, bothCnt = 0;
  logic [7:0] lastData = 8'h00;
  int divCnt = 0;

  oversample_rx uut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxEnable(rxEnable),
    .parityEnable(parityEnable), .parityOdd(parityOdd), .breakLevel(breakLevel),
    .serialIn(serialIn), .rxData(rxData), .rxValid(rxValid), .parityErr(parityErr),
    .frameErr(frameErr), .breakPulse(breakPulse), .breakActive(breakActive)
  );

  always #10 clk = ~clk;

  // tick enable, changed away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      tick16 = (divCnt == TICK_DIV - 1);
      divCnt = (divCnt == TICK_DIV - 1) ? 0 : divCnt + 1;
    end
  end

  // output monitor, sampled away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (rxValid) begin validCnt++; lastData = rxData; end
      if (parityErr) parCnt++;
      if (frameErr) frameCnt++;
      if (breakPulse) breakCnt++;
      if (parityErr && frameErr) bothCnt++;
    end
  end

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkGe(string tag, int act, int lim);
    checks++;
    if (act < lim) begin
      fails++;
      $display("FAIL %s: actual %0d expected at least %0d", tag, act, lim);
    end
  endtask

  task automatic holdLine(logic v, int ticks);
    serialIn = v;
    repeat (ticks * TICK_DIV) @(negedge clk);
  endtask

  task automatic sendFrame(logic [7:0] d, logic withPar, logic parBit, logic stopBit);
    holdLine(1'b0, 16);
    for (int i = 0; i < 8; i++) holdLine(d[i], 16);
    if (withPar) holdLine(parBit, 16);
    holdLine(stopBit, 16);
    holdLine(1'b1, 32);
  endtask

  task automatic testReset();
    checkEq("R1 rxValid after reset", rxValid, 0);
    checkEq("R1 errors after reset", parityErr + frameErr, 0);
    checkEq("R1 break after reset", breakPulse + breakActive, 0);
    checkEq("R1 rxData after reset", rxData, 0);
  endtask

  task automatic testBytes();
    logic [7:0] pats [5] = '{8'h55, 8'hA5, 8'h00, 8'hFF, 8'h3C};
    parityEnable = 1'b0;
    foreach (pats[k]) begin
      int v0 = validCnt;
      int e0 = frameCnt + parCnt;
      sendFrame(pats[k], 1'b0, 1'b0, 1'b1);
      checkEq("R3 one valid per frame", validCnt - v0, 1);
      checkEq("R3 received byte", lastData, pats[k]);
      checkEq("R3 no error on good frame", frameCnt + parCnt - e0, 0);
    end
  endtask

  task automatic testParity();
    int v0, p0;
    parityEnable = 1'b1;
    // 0xA5 has four ones: even parity bit 0, odd parity bit 1
    parityOdd = 1'b0; v0 = validCnt; p0 = parCnt;
    sendFrame(8'hA5, 1'b1, 1'b0, 1'b1);
    checkEq("R4 even parity valid", validCnt - v0, 1);
    checkEq("R4 even parity byte", lastData, 8'hA5);
    parityOdd = 1'b1; v0 = validCnt;
    sendFrame(8'h07, 1'b1, 1'b0, 1'b1); // three ones, odd -> bit 0
    checkEq("R4 odd parity valid", validCnt - v0, 1);
    checkEq("R4 odd parity byte", lastData, 8'h07);
    checkEq("R4 no parity error on good", parCnt - p0, 0);
    v0 = validCnt; p0 = parCnt;
    sendFrame(8'h07, 1'b1, 1'b1, 1'b1);
    checkEq("R4 bad parity error", parCnt - p0, 1);
    checkEq("R4 bad parity no valid", validCnt - v0, 0);
    parityOdd = 1'b0; parityEnable = 1'b0;
  endtask

  task automatic testGlitch();
    int v0 = validCnt;
    int e0 = frameCnt + parCnt;
    holdLine(1'b0, 5);
    holdLine(1'b1, 48);
    checkEq("R2 glitch gives no byte", validCnt - v0, 0);
    checkEq("R2 glitch gives no error", frameCnt + parCnt - e0, 0);
    sendFrame(8'h96, 1'b0, 1'b0, 1'b1);
    checkEq("R2 frame after glitch", lastData, 8'h96);
  endtask

  task automatic testFrame();
    int v0 = validCnt;
    int f0 = frameCnt;
    sendFrame(8'h81, 1'b0, 1'b0, 1'b0);
    checkEq("R5 frame error pulse", frameCnt - f0, 1);
    checkEq("R5 frame error no valid", validCnt - v0, 0);
  endtask

  task automatic testBoth();
    int v0 = validCnt;
    int b0 = bothCnt;
    parityEnable = 1'b1; parityOdd = 1'b0;
    sendFrame(8'h01, 1'b1, 1'b0, 1'b0); // even parity needs 1
    checkEq("R9 parity and frame same cycle", bothCnt - b0, 1);
    checkEq("R9 no valid", validCnt - v0, 0);
    parityEnable = 1'b0;
  endtask

  task automatic testDisabled();
    int s0 = validCnt + frameCnt + parCnt + breakCnt;
    rxEnable = 1'b0;
    sendFrame(8'h5A, 1'b0, 1'b0, 1'b1);
    holdLine(1'b0, 400);
    checkEq("R8 breakActive while disabled", breakActive, 0);
    holdLine(1'b1, 32);
    checkEq("R8 no pulses while disabled", validCnt + frameCnt + parCnt + breakCnt - s0, 0);
    rxEnable = 1'b1;
    holdLine(1'b1, 16);
  endtask

  task automatic testBreak();
    int b0 = breakCnt;
    int f0 = frameCnt;
    breakLevel = 2'd0; parityEnable = 1'b0; // threshold 320 ticks
    holdLine(1'b0, 300);
    checkEq("R6 no break below threshold", breakCnt - b0, 0);
    checkEq("R6 status low below threshold", breakActive, 0);
    holdLine(1'b0, 40);
    checkEq("R6 break past threshold", breakCnt - b0, 1);
    checkEq("R7 status high in break", breakActive, 1);
    checkGe("R5 repeated frame errors", frameCnt - f0, 2);
    holdLine(1'b1, 4);
    checkEq("R7 status held over short high", breakActive, 1);
    holdLine(1'b0, 350);
    checkEq("R7 no second pulse", breakCnt - b0, 1);
    holdLine(1'b1, 12);
    checkEq("R7 status clears after half bit high", breakActive, 0);
    holdLine(1'b0, 340);
    checkEq("R7 re-armed break fires", breakCnt - b0, 2);
    holdLine(1'b1, 48);
    checkEq("R7 status clears at end", breakActive, 0);
  endtask

  task automatic testBreakLevel();
    int b0 = breakCnt;
    breakLevel = 2'd1; parityEnable = 1'b1; // 4 x 176 = 704 ticks
    holdLine(1'b0, 650);
    checkEq("R6 level 1 parity no break at 650", breakCnt - b0, 0);
    holdLine(1'b0, 100);
    checkEq("R6 level 1 parity break at 750", breakCnt - b0, 1);
    holdLine(1'b1, 48);
    breakLevel = 2'd0; parityEnable = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    holdLine(1'b1, 32);
    testReset();
    testBytes();
    testParity();
    testGlitch();
    testFrame();
    testBoth();
    testDisabled();
    testBreak();
    testBreakLevel();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule